// File: doc/BRIEF.md
# Self-Checking Dual-Rail Equality Comparator

This block compares two operand words for equality and reports the result as a dual-rail pair. Each logical signal travels on two wires, a true rail and a false rail, which must always hold opposite values. Every operand bit is split into rails at the edge of the block. A leaf cell then compares each bit pair and produces a dual-rail "bits differ" result. A binary tree of merge cells folds the per-bit results into one dual-rail mismatch indication, and that indication is registered.

Every internal line is itself dual-rail coded. A single stuck-at fault therefore either leaves the output correct or turns it into a non-code word, where both rails are equal. The block decodes that non-code word into a fault flag, so a consumer trusts the mismatch bit only while the flag is low. A fault-injection port forces any one numbered internal line to a chosen constant value. This lets a test environment confirm two properties over the whole fault set. The first is that a code output is never wrong. The second is that every fault shows up as a non-code output for at least one operand pair.

Top module: `tsc_eq_tree`

## Requirements
- R1: While reset is high at a clock edge, the registered output becomes rails 01 after that edge, with mismatch low and fault flag low.
- R2: Logic 0 is coded as rails_o = 2'b01 and logic 1 as rails_o = 2'b10. Bit 1 is the true rail and bit 0 is the false rail.
- R3: With injection disabled, the output one clock after the operands are applied is a code word whose value is 1 exactly when the two operands differ.
- R4: fault_o is high exactly when the two output rails are equal (00 or 11). mismatch_o always equals the true rail and is meaningful only while fault_o is low.
- R5: Injection numbering is as follows. Leaf k owns lines 10k to 10k+9, in this order: operand-A true rail, A false rail, B true rail, B false rail, then the product terms A.t&B.f, A.f&B.t, A.t&B.t, A.f&B.f, then leaf result true rail and leaf result false rail. Merge node j owns lines 10W+2j (true rail) and 10W+2j+1 (false rail). Node j combines entries 2j and 2j+1 of the list made of the leaf results followed by the node results, and the last node is the root.
- R6: With any single line forced to 0 or to 1, every code-word output carries the correct comparison value.
- R7: For every line and every stuck value, at least one operand pair drives the output to a non-code word.
- R8: With inj_en_i low, or with inj_line_i at or above the line count (94 for W=8), injection has no effect and R3 holds.
- R9: A merge cell that receives a non-code word on one input and logic 0 on the other passes a non-code word on, so a leaf-level fault reaches the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| a_i | input | W | First operand |
| b_i | input | W | Second operand |
| inj_en_i | input | 1 | Enables stuck-at injection |
| inj_line_i | input | 7 | Index of the internal line to force (width is the log2 of line count + 1) |
| inj_val_i | input | 1 | Value the selected line is forced to |
| rails_o | output | 2 | Registered dual-rail result, {true rail, false rail} |
| mismatch_o | output | 1 | Decoded mismatch, equal to the true rail |
| fault_o | output | 1 | High when the output rails are not complementary |

## Verification
On every cycle, the assertions check the following: a code output that matches the operand comparison whenever injection is off or aimed outside the line range, correct values on every code output even under injection, leaf correctness without injection, non-code propagation through each merge cell, and the reset value. Only the bench scenarios can show the self-testing property, because it needs a fault held across a set of operand pairs and an observation that some pair produced a non-code word. The bench also walks every line and both stuck values, and compares all operand pairs fault-free.

// File: rtl/tsc_pkg.sv
package tsc_pkg;

    // Dual-rail signal: t is the true rail, f the false rail.
    typedef struct packed {
        logic t;
        logic f;
    } rail_t;

    localparam rail_t RAIL_ZERO  = '{t: 1'b0, f: 1'b1};
    localparam int    LEAF_LINES = 10;
    localparam int    NODE_LINES = 2;

    // Replace a line by the stuck value when its mask bit is set.
    function automatic logic pin_line(input logic x, input logic m, input logic v);
        return m ? v : x;
    endfunction

    function automatic logic is_code(input rail_t r);
        return r.t ^ r.f;
    endfunction

    function automatic int line_count(input int w);
        return LEAF_LINES * w + NODE_LINES * (w - 1);
    endfunction

endpackage

// File: rtl/tsc_fault_sel.sv
module tsc_fault_sel #(
    parameter int LINES = 94,
    parameter int LW    = 7
) (
    input  logic             en_i,
    input  logic [LW-1:0]    line_i,
    output logic [LINES-1:0] mask_o
);
    // One comparator per line; indices at or above LINES match nothing.
    for (genvar i = 0; i < LINES; i++) begin : g_dec
        assign mask_o[i] = en_i && (line_i == LW'(i));
    end
endmodule

// File: rtl/tsc_leaf_cell.sv
module tsc_leaf_cell
    import tsc_pkg::*;
(
    input  logic                  a_i,
    input  logic                  b_i,
    input  logic [LEAF_LINES-1:0] sa_mask_i,
    input  logic                  sa_val_i,
    output rail_t                 res_o
);
    logic at, af, bt, bf;
    logic p_tf, p_ft, p_tt, p_ff;

    always_comb begin
        at   = pin_line(a_i,  sa_mask_i[0], sa_val_i);
        af   = pin_line(~a_i, sa_mask_i[1], sa_val_i);
        bt   = pin_line(b_i,  sa_mask_i[2], sa_val_i);
        bf   = pin_line(~b_i, sa_mask_i[3], sa_val_i);
        p_tf = pin_line(at & bf, sa_mask_i[4], sa_val_i);
        p_ft = pin_line(af & bt, sa_mask_i[5], sa_val_i);
        p_tt = pin_line(at & bt, sa_mask_i[6], sa_val_i);
        p_ff = pin_line(af & bf, sa_mask_i[7], sa_val_i);
        res_o.t = pin_line(p_tf | p_ft, sa_mask_i[8], sa_val_i);
        res_o.f = pin_line(p_tt | p_ff, sa_mask_i[9], sa_val_i);
    end

    always_comb begin
        if (sa_mask_i == '0) begin
            AST_LEAF_CORRECT: assert (is_code(res_o) && (res_o.t == (a_i ^ b_i))); // R3
        end
    end
endmodule

// File: rtl/tsc_merge_cell.sv
module tsc_merge_cell
    import tsc_pkg::*;
(
    input  rail_t                 x_i,
    input  rail_t                 y_i,
    input  logic [NODE_LINES-1:0] sa_mask_i,
    input  logic                  sa_val_i,
    output rail_t                 z_o
);
    // Dual-rail OR: true rails are ORed, false rails are ANDed.
    always_comb begin
        z_o.t = pin_line(x_i.t | y_i.t, sa_mask_i[0], sa_val_i);
        z_o.f = pin_line(x_i.f & y_i.f, sa_mask_i[1], sa_val_i);
    end

    always_comb begin
        if (sa_mask_i == '0 && ((!is_code(x_i) && y_i == RAIL_ZERO) ||
                                (!is_code(y_i) && x_i == RAIL_ZERO))) begin
            AST_NONCODE_PASSES: assert (!is_code(z_o)); // R9
        end
    end
endmodule

// File: rtl/tsc_eq_tree.sv
module tsc_eq_tree
    import tsc_pkg::*;
#(
    parameter  int W     = 8,
    localparam int LINES = line_count(W),
    localparam int LW    = $clog2(LINES + 1)
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic [W-1:0]  a_i,
    input  logic [W-1:0]  b_i,
    input  logic          inj_en_i,
    input  logic [LW-1:0] inj_line_i,
    input  logic          inj_val_i,
    output logic [1:0]    rails_o,
    output logic          mismatch_o,
    output logic          fault_o
);
    localparam int NODES     = W - 1;
    localparam int NODE_BASE = LEAF_LINES * W;
    localparam int ROOT      = 2 * W - 2;

    logic [LINES-1:0] mask;
    rail_t            tr [2*W-1];
    rail_t            rails_q;

    tsc_fault_sel #(.LINES(LINES), .LW(LW)) u_sel (
        .en_i   (inj_en_i),
        .line_i (inj_line_i),
        .mask_o (mask)
    );

    for (genvar k = 0; k < W; k++) begin : g_leaf
        tsc_leaf_cell u_leaf (
            .a_i       (a_i[k]),
            .b_i       (b_i[k]),
            .sa_mask_i (mask[LEAF_LINES*k +: LEAF_LINES]),
            .sa_val_i  (inj_val_i),
            .res_o     (tr[k])
        );
    end

    for (genvar j = 0; j < NODES; j++) begin : g_node
        tsc_merge_cell u_node (
            .x_i       (tr[2*j]),
            .y_i       (tr[2*j+1]),
            .sa_mask_i (mask[NODE_BASE + NODE_LINES*j +: NODE_LINES]),
            .sa_val_i  (inj_val_i),
            .z_o       (tr[W+j])
        );
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) rails_q <= RAIL_ZERO;
        else       rails_q <= tr[ROOT];
    end

    assign rails_o    = rails_q;
    assign mismatch_o = rails_q.t;
    assign fault_o    = (rails_q.t == rails_q.f);

    AST_RESET_VALUE: assert property (@(posedge clk_i)
        rst_i |=> (rails_o == 2'b01 && !fault_o && !mismatch_o)); // R1

    AST_CLEAN_CODE: assert property (@(posedge clk_i) disable iff (rst_i)
        !inj_en_i |=> (!fault_o && mismatch_o == $past(a_i != b_i))); // R3

    AST_FAULT_SECURE: assert property (@(posedge clk_i) disable iff (rst_i)
        1'b1 |=> (fault_o || mismatch_o == $past(a_i != b_i))); // R6

    AST_OUT_OF_RANGE: assert property (@(posedge clk_i) disable iff (rst_i)
        (int'(inj_line_i) >= LINES) |=> (!fault_o && mismatch_o == $past(a_i != b_i))); // R8
endmodule

// File: tb/sim_tsc_eq_tree.sv
module sim_tsc_eq_tree;
    localparam int W     = 8;
    localparam int LINES = 94;
    localparam int LW    = 7;

    typedef struct {
        logic  exp_mm;
        bit    strict;
        string req;
    } item_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [W-1:0]  a = '0, b = '0;
    logic          inj_en = 1'b0;
    logic [LW-1:0] inj_line = '0;
    logic          inj_val = 1'b0;
    logic [1:0]    rails;
    logic          mm, flt;

    int    checks = 0, failures = 0;
    bit    noncode_seen = 1'b0;
    bit    finished = 1'b0;
    item_t sb[$];

    always #4 clk = ~clk;

    tsc_eq_tree #(.W(W)) u0 (
        .clk_i(clk), .rst_i(rst), .a_i(a), .b_i(b),
        .inj_en_i(inj_en), .inj_line_i(inj_line), .inj_val_i(inj_val),
        .rails_o(rails), .mismatch_o(mm), .fault_o(flt)
    );

    task automatic chk(input bit ok, input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic drive(input logic [W-1:0] av, input logic [W-1:0] bv, input logic en,
                         input int line, input logic val, input bit strict, input string req);
        item_t it;
        @(negedge clk);
        a = av; b = bv; inj_en = en; inj_line = LW'(line); inj_val = val;
        it.exp_mm = (av != bv);
        it.strict = strict;
        it.req    = req;
        sb.push_back(it);
    endtask

    // Monitor: the output register updates at the posedge after the drive.
    initial forever begin
        item_t it;
        logic  code;
        @(posedge clk); #1;
        if (sb.size() > 0) begin
            it   = sb.pop_front();
            code = rails[1] ^ rails[0];
            // R4: flag and decoded bit follow the rails
            chk(flt == ~code && mm == rails[1], "R4", {rails, mm, flt}, {rails, rails[1], ~code});
            if (it.strict) begin
                // R2 coding: logic 1 -> 10, logic 0 -> 01
                chk(rails == {it.exp_mm, ~it.exp_mm}, it.req, {2'b00, rails}, {2'b00, it.exp_mm, ~it.exp_mm});
            end else begin
                if (!code) noncode_seen = 1'b1;
                chk(!code || mm == it.exp_mm, it.req, {2'b00, rails}, {2'b00, it.exp_mm, ~it.exp_mm});
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(rails == 2'b01 && !mm && !flt, "R1", {rails, mm, flt}, 4'b0100);
        rst = 1'b0;

        // R3 and R2: every operand pair, no injection
        for (int i = 0; i < 256; i++)
            for (int j = 0; j < 256; j++)
                drive(W'(i), W'(j), 1'b0, 0, 1'b0, 1'b1, "R3");

        // R8: indices outside the line range, and a disabled selector
        for (int ln = LINES; ln < 128; ln++) begin
            drive(8'h5A, 8'h5A, 1'b1, ln, ln[0], 1'b1, "R8");
            drive(8'h5A, 8'h5B, 1'b1, ln, ln[0], 1'b1, "R8");
        end
        drive(8'h00, 8'h00, 1'b0, 6, 1'b1, 1'b1, "R8");
        drive(8'h80, 8'h00, 1'b0, 93, 1'b0, 1'b1, "R8");

        // R5, R6, R7: each numbered line stuck at each value
        for (int ln = 0; ln < LINES; ln++) begin
            for (int v = 0; v < 2; v++) begin
                repeat (2) @(negedge clk);
                noncode_seen = 1'b0;
                for (int k = 0; k < W; k++)
                    for (int c = 0; c < 4; c++)
                        for (int bs = 0; bs < 2; bs++) begin
                            logic [W-1:0] base, av, bv;
                            base = bs[0] ? 8'hFF : 8'h00;
                            av = base; bv = base;
                            av[k] = c[1]; bv[k] = c[0];
                            drive(av, bv, 1'b1, ln, v[0], 1'b0, "R6");
                        end
                repeat (3) @(negedge clk);
                // R7 self-testing; leaf lines also need R9 propagation
                chk(noncode_seen, (ln < 80) ? "R7 R9" : "R7",
                    {3'b000, noncode_seen}, 4'b0001);
            end
        end

        // R1: reset in the middle of operation with a mismatch registered
        drive(8'h01, 8'h02, 1'b0, 0, 1'b0, 1'b1, "R3");
        repeat (3) @(negedge clk);
        chk(rails == 2'b10, "R3", {2'b00, rails}, 4'b0010);
        rst = 1'b1;
        @(negedge clk);
        chk(rails == 2'b01 && !mm && !flt, "R1", {rails, mm, flt}, 4'b0100);
        rst = 1'b0;

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule